// File: doc/BRIEF.md
# Dual-Page Translation Lookaside Buffer with Software Refill

This block translates 32-bit virtual addresses into 36-bit physical addresses through a small fully associative table. Each slot pairs two neighbouring virtual pages under one tag. A single virtual address bit picks either the even frame or the odd frame. Every slot carries its own page size, from 1 KB up to 256 MB in steps of four. A slot matches on an address-space identifier, unless it is flagged as global.

The lookup side takes one request per cycle and answers one cycle later. The answer is either a physical address with a cache attribute or an exception code. With an exception it also returns the faulting address, so that a software handler can rebuild the missing slot.

The management side lets software write a slot by index, read a slot back by index, and probe for the slot that covers a given virtual page pair and identifier. The block has no page-table walker. Refill is left entirely to software.

Top module: `tlb_dual_page`

## Requirements
- R1: After reset `rs_valid` is low, and reading any slot returns zero in `rd_tag`, `rd_lo0` and `rd_lo1`.
- R2: `mg_op`=1 writes slot `mg_index` at the next clock edge and `mg_op`=2 returns it one cycle later. The tag layout is {page-pair number[33:13], identifier[12:5], global[4], size code[3:0]}. The frame layout is {frame number[30:5], cache attribute[4:2], dirty[1], valid[0]}. Page-pair bits that lie under the slot's size mask are stored and read back as zero.
- R3: A slot matches only when its identifier equals `lk_asid` or its global bit is set. Its page-pair number must also equal `lk_vaddr[31:11]` on every bit above the low 2×size bits.
- R4: Size code s (0..9) gives pages of 2^(10+2s) bytes, and `lk_vaddr[10+2s]` selects the odd frame. On success `rs_paddr` takes the frame number shifted left by 10 for its upper bits and `lk_vaddr` for its low 10+2s bits. `rs_cattr` is the cache attribute of the chosen frame.
- R5: A request with `lk_valid` high gives `rs_valid` high exactly one cycle later. In a cycle without a result, `rs_valid`, `rs_exc` and `rs_paddr` are zero.
- R6: When no slot matches, `rs_exc` is 1 (refill), `rs_badva` is the request address and `rs_badvpn2` is its bits [31:11]. On any exception `rs_paddr` and `rs_cattr` are zero. Without one, `rs_badva` and `rs_badvpn2` are zero.
- R7: When the chosen frame of the matching slot is not valid, `rs_exc` is 2 (invalid).
- R8: When `lk_store` is high, the chosen frame is valid and its dirty bit is clear, `rs_exc` is 3 (modified). A load to the same frame succeeds.
- R9: When `lk_in_handler` is high, any of codes 1..3 is reported as code 4 (nested fault) instead.
- R10: `mg_op`=3 looks up the page-pair number and identifier fields of `mg_tag`. One cycle later `pr_hit` shows whether a slot matched and `pr_index` gives that slot's index, or zero when none did.
- R11: When several slots match, both lookup and probe use the lowest-indexed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Translation request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_store | input | 1 | Request is a store |
| lk_in_handler | input | 1 | A translation fault is already being serviced |
| rs_valid | output | 1 | Result present |
| rs_paddr | output | 36 | Physical address |
| rs_cattr | output | 3 | Cache attribute of the chosen frame |
| rs_exc | output | 3 | 0 none, 1 refill, 2 invalid, 3 modified, 4 nested |
| rs_badva | output | 32 | Faulting virtual address |
| rs_badvpn2 | output | 21 | Page-pair number of the faulting address |
| mg_op | input | 2 | 0 idle, 1 write, 2 read, 3 probe |
| mg_index | input | 4 | Slot index for write and read |
| mg_tag | input | 34 | Tag for write, page-pair number and identifier for probe |
| mg_lo0 | input | 31 | Even frame for write |
| mg_lo1 | input | 31 | Odd frame for write |
| rd_tag | output | 34 | Tag read back |
| rd_lo0 | output | 31 | Even frame read back |
| rd_lo1 | output | 31 | Odd frame read back |
| pr_hit | output | 1 | Probe found a slot |
| pr_index | output | 4 | Index found by probe |

## Verification
The assertions cover every cycle for a set of rules. Each request gives exactly one result one cycle later, and the result outputs are clean when idle. Offset bits always pass through on a success. A faulting address is always reported. Nested-fault coding follows the handler flag, and a modified fault only ever follows a store. Several behaviours depend on stored contents, so only the bench scenarios can show them. These include page-size masking, the odd/even frame choice, the identifier and global rules, lowest-index priority and the stored clearing of masked tag bits. The bench sweeps every size code at both offset extremes, both frames, both access kinds and both identifiers, and checks each answer against arithmetic done in the bench.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W    = 32;
    localparam int PA_W    = 36;
    localparam int ASID_W  = 8;
    localparam int MIN_OFS = 10;
    localparam int N_SIZES = 10;
    localparam int CATTR_W = 3;
    localparam int SZ_W    = 4;
    localparam int VPN2_W  = VA_W - MIN_OFS - 1;
    localparam int PFN_W   = PA_W - MIN_OFS;
    localparam int TAG_W   = VPN2_W + ASID_W + 1 + SZ_W;
    localparam int HALF_W  = PFN_W + CATTR_W + 2;

    typedef struct packed {
        logic [PFN_W-1:0]   pfn;
        logic [CATTR_W-1:0] cattr;
        logic               dirty;
        logic               valid;
    } half_t;

    typedef struct packed {
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [SZ_W-1:0]   size;
    } tag_t;

    typedef struct packed {
        tag_t  tag;
        half_t lo0;
        half_t lo1;
    } entry_t;

    typedef enum logic [2:0] {
        EXC_NONE     = 3'd0,
        EXC_REFILL   = 3'd1,
        EXC_INVALID  = 3'd2,
        EXC_MODIFIED = 3'd3,
        EXC_DOUBLE   = 3'd4
    } exc_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_PROBE = 2'd3
    } op_e;

    function automatic logic [SZ_W-1:0] size_sat(input logic [SZ_W-1:0] sz);
        return (int'(sz) > N_SIZES - 1) ? SZ_W'(N_SIZES - 1) : sz;
    endfunction

    // Bits of the page-pair number swallowed by a larger page.
    function automatic logic [VPN2_W-1:0] vpn2_mask(input logic [SZ_W-1:0] sz);
        logic [VPN2_W-1:0] m;
        m = '0;
        for (int i = 0; i < N_SIZES - 1; i++) begin
            if (i < int'(size_sat(sz))) m[2*i +: 2] = 2'b11;
        end
        return m;
    endfunction

    // Position of the even/odd frame select bit in the virtual address.
    function automatic int sel_pos(input logic [SZ_W-1:0] sz);
        return MIN_OFS + 2 * int'(size_sat(sz));
    endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
(
    input  tag_t              tag,
    input  logic [VPN2_W-1:0] vpn2,
    input  logic [ASID_W-1:0] asid,
    output logic              hit
);
    logic [VPN2_W-1:0] care;
    logic              same_space;

    always_comb begin
        care       = ~vpn2_mask(tag.size);
        same_space = tag.glob || (tag.asid == asid);
        hit        = same_space && (((tag.vpn2 ^ vpn2) & care) == '0);
    end
endmodule

// File: rtl/tlb_first.sv
module tlb_first #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  hits,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is the last one written.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
(
    input  entry_t             ent,
    input  logic [VA_W-1:0]    va,
    input  logic               store,
    input  logic               hit,
    input  logic               in_handler,
    output exc_e               exc,
    output logic [PA_W-1:0]    paddr,
    output logic [CATTR_W-1:0] cattr
);
    int              sp;
    logic            odd;
    half_t           half;
    logic [PA_W-1:0] offm;
    logic [PA_W-1:0] base;
    exc_e            fault;

    always_comb begin
        sp    = sel_pos(ent.tag.size);
        odd   = |((va >> sp) & VA_W'(1));
        half  = odd ? ent.lo1 : ent.lo0;
        offm  = (PA_W'(1) << sp) - PA_W'(1);
        base  = {half.pfn, {MIN_OFS{1'b0}}};
        fault = EXC_NONE;
        if (!hit)                         fault = EXC_REFILL;
        else if (!half.valid)             fault = EXC_INVALID;
        else if (store && !half.dirty)    fault = EXC_MODIFIED;
        exc   = (fault != EXC_NONE && in_handler) ? EXC_DOUBLE : fault;
        paddr = (fault == EXC_NONE) ? ((base & ~offm) | (PA_W'(va) & offm)) : '0;
        cattr = (fault == EXC_NONE) ? half.cattr : '0;
    end
endmodule

// File: rtl/tlb_dual_page.sv
module tlb_dual_page
    import tlb_pkg::*;
#(
    parameter int  ENTRIES = 16,
    localparam int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [VA_W-1:0]    lk_vaddr,
    input  logic [ASID_W-1:0]  lk_asid,
    input  logic               lk_store,
    input  logic               lk_in_handler,
    output logic               rs_valid,
    output logic [PA_W-1:0]    rs_paddr,
    output logic [CATTR_W-1:0] rs_cattr,
    output logic [2:0]         rs_exc,
    output logic [VA_W-1:0]    rs_badva,
    output logic [VPN2_W-1:0]  rs_badvpn2,
    input  logic [1:0]         mg_op,
    input  logic [IW-1:0]      mg_index,
    input  logic [TAG_W-1:0]   mg_tag,
    input  logic [HALF_W-1:0]  mg_lo0,
    input  logic [HALF_W-1:0]  mg_lo1,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [HALF_W-1:0]  rd_lo0,
    output logic [HALF_W-1:0]  rd_lo1,
    output logic               pr_hit,
    output logic [IW-1:0]      pr_index
);
    typedef struct packed {
        logic               rs_valid;
        logic [PA_W-1:0]    paddr;
        logic [CATTR_W-1:0] cattr;
        exc_e               exc;
        logic [VA_W-1:0]    badva;
        logic [VPN2_W-1:0]  badvpn2;
        entry_t             rd;
        logic               pr_hit;
        logic [IW-1:0]      pr_index;
    } res_t;

    entry_t ent_q [ENTRIES];
    entry_t ent_d [ENTRIES];
    res_t   res_q, res_d;

    // Match arrays for the lookup side and the probe side
    tag_t               pr_tag;
    logic [ENTRIES-1:0] lk_hits, pr_hits;
    logic               lk_found, pr_found;
    logic [IW-1:0]      lk_idx, pr_idx;

    assign pr_tag = tag_t'(mg_tag);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        tlb_match i_lk_match (
            .tag  (ent_q[g].tag),
            .vpn2 (lk_vaddr[VA_W-1 -: VPN2_W]),
            .asid (lk_asid),
            .hit  (lk_hits[g])
        );
        tlb_match i_pr_match (
            .tag  (ent_q[g].tag),
            .vpn2 (pr_tag.vpn2),
            .asid (pr_tag.asid),
            .hit  (pr_hits[g])
        );
    end

    tlb_first #(.N(ENTRIES), .IW(IW)) i_lk_first (
        .hits (lk_hits), .found (lk_found), .idx (lk_idx)
    );
    tlb_first #(.N(ENTRIES), .IW(IW)) i_pr_first (
        .hits (pr_hits), .found (pr_found), .idx (pr_idx)
    );

    exc_e               xl_exc;
    logic [PA_W-1:0]    xl_paddr;
    logic [CATTR_W-1:0] xl_cattr;

    tlb_xlate i_xlate (
        .ent        (ent_q[lk_idx]),
        .va         (lk_vaddr),
        .store      (lk_store),
        .hit        (lk_found),
        .in_handler (lk_in_handler),
        .exc        (xl_exc),
        .paddr      (xl_paddr),
        .cattr      (xl_cattr)
    );

    tag_t wr_tag;

    always_comb begin
        ent_d          = ent_q;
        res_d          = res_q;
        res_d.rs_valid = lk_valid;
        res_d.exc      = EXC_NONE;
        res_d.paddr    = '0;
        res_d.cattr    = '0;
        res_d.badva    = '0;
        res_d.badvpn2  = '0;
        if (lk_valid) begin
            res_d.exc   = xl_exc;
            res_d.paddr = xl_paddr;
            res_d.cattr = xl_cattr;
            if (xl_exc != EXC_NONE) begin
                res_d.badva   = lk_vaddr;
                res_d.badvpn2 = lk_vaddr[VA_W-1 -: VPN2_W];
            end
        end

        wr_tag      = tag_t'(mg_tag);
        wr_tag.vpn2 = wr_tag.vpn2 & ~vpn2_mask(wr_tag.size);
        case (op_e'(mg_op))
            OP_WRITE: begin
                ent_d[mg_index].tag = wr_tag;
                ent_d[mg_index].lo0 = half_t'(mg_lo0);
                ent_d[mg_index].lo1 = half_t'(mg_lo1);
            end
            OP_READ:  res_d.rd = ent_q[mg_index];
            OP_PROBE: begin
                res_d.pr_hit   = pr_found;
                res_d.pr_index = pr_idx;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
            res_q <= '0;
        end else begin
            ent_q <= ent_d;
            res_q <= res_d;
        end
    end

    assign rs_valid   = res_q.rs_valid;
    assign rs_paddr   = res_q.paddr;
    assign rs_cattr   = res_q.cattr;
    assign rs_exc     = res_q.exc;
    assign rs_badva   = res_q.badva;
    assign rs_badvpn2 = res_q.badvpn2;
    assign rd_tag     = res_q.rd.tag;
    assign rd_lo0     = res_q.rd.lo0;
    assign rd_lo1     = res_q.rd.lo1;
    assign pr_hit     = res_q.pr_hit;
    assign pr_index   = res_q.pr_index;

    // Result timing
    assert_result_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_valid);
    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rs_valid);
    assert_idle_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |-> (rs_exc == 3'd0 && rs_paddr == '0));
    // Offset passes through untouched
    assert_offset_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_exc == 3'd0) |-> rs_paddr[MIN_OFS-1:0] == $past(lk_vaddr[MIN_OFS-1:0]));
    // Faulting address reported
    assert_badva_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_exc != 3'd0) |-> rs_badva == $past(lk_vaddr));
    // Nested fault coding
    assert_nested_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_exc != 3'd0) |-> ((rs_exc == 3'd4) == $past(lk_in_handler)));
    // Modified fault only on a store
    assert_modified_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_exc == 3'd3) |-> $past(lk_store));
endmodule

// File: tb/test_tlb_dual_page.sv
`timescale 1ns/1ps
module test_tlb_dual_page;
    import tlb_pkg::*;
    localparam int N = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               lk_valid = 1'b0;
    logic [VA_W-1:0]    lk_vaddr = '0;
    logic [ASID_W-1:0]  lk_asid = '0;
    logic               lk_store = 1'b0;
    logic               lk_in_handler = 1'b0;
    logic               rs_valid;
    logic [PA_W-1:0]    rs_paddr;
    logic [CATTR_W-1:0] rs_cattr;
    logic [2:0]         rs_exc;
    logic [VA_W-1:0]    rs_badva;
    logic [VPN2_W-1:0]  rs_badvpn2;
    logic [1:0]         mg_op = 2'd0;
    logic [3:0]         mg_index = '0;
    logic [TAG_W-1:0]   mg_tag = '0;
    logic [HALF_W-1:0]  mg_lo0 = '0;
    logic [HALF_W-1:0]  mg_lo1 = '0;
    logic [TAG_W-1:0]   rd_tag;
    logic [HALF_W-1:0]  rd_lo0;
    logic [HALF_W-1:0]  rd_lo1;
    logic               pr_hit;
    logic [3:0]         pr_index;

    always #4 clk = ~clk;

    tlb_dual_page #(.ENTRIES(N)) i_tlb_dual_page (.*);

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Bench-side copy of what software wrote
    logic [VPN2_W-1:0]  m_vpn  [N];
    logic [ASID_W-1:0]  m_asid [N];
    logic               m_g    [N];
    logic [3:0]         m_sz   [N];
    logic [PFN_W-1:0]   m_pfn  [N][2];
    logic [CATTR_W-1:0] m_c    [N][2];
    logic               m_d    [N][2];
    logic               m_v    [N][2];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [HALF_W-1:0] half_word(input int i, input int h);
        return {m_pfn[i][h], m_c[i][h], m_d[i][h], m_v[i][h]};
    endfunction

    function automatic logic [VPN2_W-1:0] stored_vpn(input int i);
        longint msk;
        msk = (64'd1 << (2 * int'(m_sz[i]))) - 1;
        return VPN2_W'(longint'(m_vpn[i]) & ~msk);
    endfunction

    function automatic int find(input logic [VPN2_W-1:0] vpn, input logic [ASID_W-1:0] a);
        for (int i = 0; i < N; i++) begin
            longint msk;
            msk = (64'd1 << (2 * int'(m_sz[i]))) - 1;
            if ((m_g[i] || m_asid[i] == a) &&
                ((longint'(m_vpn[i] ^ vpn) & ~msk) == 0)) return i;
        end
        return -1;
    endfunction

    task automatic write_entry(input int i);
        mg_op    = 2'd1;
        mg_index = 4'(i);
        mg_tag   = {m_vpn[i], m_asid[i], m_g[i], m_sz[i]};
        mg_lo0   = half_word(i, 0);
        mg_lo1   = half_word(i, 1);
        @(negedge clk);
        mg_op    = 2'd0;
    endtask

    task automatic read_check(input int i, input bit zero, input string req);
        logic [TAG_W-1:0]  et;
        logic [HALF_W-1:0] e0, e1;
        mg_op    = 2'd2;
        mg_index = 4'(i);
        @(negedge clk);
        mg_op    = 2'd0;
        et = zero ? '0 : {stored_vpn(i), m_asid[i], m_g[i], m_sz[i]};
        e0 = zero ? '0 : half_word(i, 0);
        e1 = zero ? '0 : half_word(i, 1);
        chk(rd_tag == et, req, "read tag", 64'(rd_tag), 64'(et));
        chk({rd_lo0, rd_lo1} == {e0, e1}, req, "read frames",
            64'({rd_lo0, rd_lo1}), 64'({e0, e1}));
    endtask

    task automatic probe_check(input logic [VPN2_W-1:0] vpn, input logic [ASID_W-1:0] a,
                               input string req);
        int ei;
        mg_op  = 2'd3;
        mg_tag = {vpn, a, 1'b0, 4'd0};
        @(negedge clk);
        mg_op  = 2'd0;
        ei = find(vpn, a);
        chk({pr_hit, pr_index} == {ei >= 0, 4'(ei >= 0 ? ei : 0)}, req, "probe",
            64'({pr_hit, pr_index}), 64'({ei >= 0, 4'(ei >= 0 ? ei : 0)}));
    endtask

    task automatic lookup(input logic [31:0] va, input logic [7:0] a, input bit st,
                          input bit inh, input string force_req);
        int          ei, sp, h, e;
        longint      offm, pa;
        logic [2:0]  ec;
        string       req;
        lk_valid = 1'b1; lk_vaddr = va; lk_asid = a; lk_store = st; lk_in_handler = inh;
        ei = find(va[31:11], a);
        e  = 0; pa = 0; ec = '0;
        if (ei < 0) e = 1;
        else begin
            sp   = MIN_OFS + 2 * int'(m_sz[ei]);
            h    = int'((longint'(va) >> sp) & 1);
            offm = (64'd1 << sp) - 1;
            if (!m_v[ei][h]) e = 2;
            else if (st && !m_d[ei][h]) e = 3;
            else begin
                pa = ((longint'(m_pfn[ei][h]) << MIN_OFS) & ~offm) | (longint'(va) & offm);
                ec = m_c[ei][h];
            end
        end
        if (e != 0 && inh) e = 4;
        case (e)
            0: req = "R4";
            1: req = "R6";
            2: req = "R7";
            3: req = "R8";
            default: req = "R9";
        endcase
        if (force_req != "") req = force_req;
        @(negedge clk);
        lk_valid = 1'b0;
        chk({rs_valid, rs_exc, rs_paddr, rs_cattr} == {1'b1, 3'(e), 36'(pa), ec}, req,
            "valid/exc/paddr/cattr", 64'({rs_valid, rs_exc, rs_paddr, rs_cattr}),
            64'({1'b1, 3'(e), 36'(pa), ec}));
        chk({rs_badva, rs_badvpn2} == (e != 0 ? {va, va[31:11]} : 53'd0), req,
            "badva/badvpn2", 64'({rs_badva, rs_badvpn2}),
            64'(e != 0 ? {va, va[31:11]} : 53'd0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(rs_valid == 1'b0, "R1", "rs_valid after reset", 64'(rs_valid), 64'd0);
        for (int i = 0; i < N; i++) read_check(i, 1'b1, "R1");

        // Build a table covering every size code
        for (int i = 0; i < N; i++) begin
            m_sz[i]   = 4'(i % N_SIZES);
            m_vpn[i]  = VPN2_W'($urandom);
            m_asid[i] = 8'(i % 5);
            m_g[i]    = (i % 7 == 3);
            for (int h = 0; h < 2; h++) begin
                m_pfn[i][h] = PFN_W'($urandom);
                m_c[i][h]   = 3'((i + 3 * h) % 8);
            end
            m_v[i][0] = (i % 4 != 1); m_d[i][0] = (i % 3 != 0);
            m_v[i][1] = (i % 5 != 2); m_d[i][1] = (i % 2 == 0);
        end
        // Slot 15 duplicates slot 2's tag with different frames
        m_vpn[15] = m_vpn[2]; m_asid[15] = m_asid[2]; m_g[15] = m_g[2]; m_sz[15] = m_sz[2];
        m_v[15][0] = 1'b1; m_v[15][1] = 1'b1; m_d[15][0] = 1'b1; m_d[15][1] = 1'b1;
        m_v[2][0] = 1'b1; m_v[2][1] = 1'b1; m_d[2][0] = 1'b1; m_d[2][1] = 1'b1;
        for (int i = 0; i < N; i++) write_entry(i);

        // R2: readback with masked page-pair bits cleared
        for (int i = 0; i < N; i++) read_check(i, 1'b0, "R2");

        // Sweep every slot: identifier, frame, access kind, handler flag, offset extremes
        for (int i = 0; i < N; i++) begin
            for (int ao = 0; ao < 2; ao++)
            for (int h = 0; h < 2; h++)
            for (int st = 0; st < 2; st++)
            for (int inh = 0; inh < 2; inh++)
            for (int hi = 0; hi < 2; hi++) begin
                int          sp;
                longint      base, va;
                logic [7:0]  a;
                sp   = MIN_OFS + 2 * int'(m_sz[i]);
                base = (longint'(m_vpn[i]) << 11) & ~((64'd1 << (sp + 1)) - 1);
                va   = base | (longint'(h) << sp) | (hi != 0 ? ((64'd1 << sp) - 1) : 0);
                a    = m_asid[i] + 8'(ao);
                lookup(32'(va), a, st[0], inh[0], (ao != 0 && !m_g[i]) ? "R3" : "");
            end
        end

        // R11: duplicate tag, lowest index wins in lookup and probe
        lookup({m_vpn[2], 11'h155}, m_asid[2], 1'b0, 1'b0, "R11");
        probe_check(m_vpn[2], m_asid[2], "R11");

        // R10: probes of every slot and of some misses
        for (int i = 0; i < N; i++) probe_check(m_vpn[i], m_asid[i], "R10");
        for (int k = 0; k < 8; k++) probe_check(VPN2_W'($urandom), 8'(200 + k), "R10");

        // R5: result lasts one cycle only
        lookup({m_vpn[4], 11'h0}, m_asid[4], 1'b0, 1'b0, "R5");
        @(negedge clk);
        chk({rs_valid, rs_exc} == 4'd0, "R5", "idle after result", 64'({rs_valid, rs_exc}), 64'd0);

        // Scattered addresses and identifiers
        for (int k = 0; k < 300; k++)
            lookup($urandom, 8'($urandom % 6), 1'($urandom), ($urandom % 4 == 0), "");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule